// File: doc/BRIEF.md
# Narrow-Link Packet Receiver and Deframer

This block sits behind the deserializer of a packet link whose lane count per direction is chosen at run time. Each clock it takes an even/odd pair of lane beats, because the link transfers on both clock edges. It packs the beats into 32-bit words, least-significant bits first. From the resulting word stream it separates each packet into three parts: a command word, an optional 40-bit address and a counted run of payload words.

The command word sets the packet's framing. Bits [31:28] give the payload length in 32-bit words (0 to 15). Bit 27 says whether an address word follows. Bits [26:25] give how many high-order bytes of the last payload word are padding. Bits [7:0] supply the upper eight bits of the address, and the word after the command supplies the lower 32 bits. The length count ends the packet. An end marker that arrives before the count is reached cuts the packet short and raises an error pulse.

Top module: `pkt_link_rx`

## Requirements
- R1: A synchronous active-high `rst` discards any partly gathered word and returns the block to expecting a command word. In the cycle after a reset edge, every valid, last and error output is low.
- R2: `width_sel` codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 active lanes, and codes 5 to 7 act as 16. On a beat cycle the low lanes of `lane_even` take the next bits of the word, and the low lanes of `lane_odd` take the bits above those. A word therefore completes after 16, 8, 4, 2 or 1 beat cycles. Lanes above the selected count are ignored.
- R3: The first word of a packet appears on `cmd_word` with a one-cycle `cmd_valid` pulse, one clock after the beat cycle that completes it. `cmd_len` shows bits [31:28], and `cmd_has_addr` shows bit 27.
- R4: When bit 27 of the command is set, the next word is the address. `addr_valid` pulses, and `addr` is {command bits [7:0], that word}.
- R5: After the command (and the address, if there is one), exactly `cmd_len` words come out as payload with `pay_valid`. `pay_last` marks the last of them. On that last word `pay_keep` is 4'hF shifted right by the pad count in command bits [26:25]. On every other payload word it is 4'hF.
- R6: A packet ends when its counted words are done, even with no end marker. The next word is taken as a command.
- R7: If `eop_in` comes with a word before the packet's count is complete, that word is emitted as usual and `trunc_err` pulses with it. A truncated payload word also carries `pay_last`. The next word is taken as a command.
- R8: `eop_in` is sampled only in the beat cycle that completes a word. On other beat cycles and on idle cycles it has no effect. A marker on the counted last word raises no error.
- R9: The lane count is taken from `width_sel` only on the first beat of a command word. A change made at any other time, including partway through a command word, takes effect from the next command word.
- R10: Cycles with `beat_valid` low change no state, whatever the lane and marker inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | The even/odd beat pair is valid this cycle |
| lane_even | input | 16 | Beat taken on the first edge |
| lane_odd | input | 16 | Beat taken on the second edge |
| width_sel | input | 3 | Active lane count code |
| eop_in | input | 1 | End-of-packet marker, sampled with the word-completing beat |
| cmd_valid | output | 1 | Command word pulse |
| cmd_word | output | 32 | Last command word |
| cmd_len | output | 4 | Payload length of the last command |
| cmd_has_addr | output | 1 | Address flag of the last command |
| addr_valid | output | 1 | Address pulse |
| addr | output | 40 | Joined 40-bit address |
| pay_valid | output | 1 | Payload word pulse |
| pay_data | output | 32 | Payload word |
| pay_last | output | 1 | Final payload word of the packet |
| pay_keep | output | 4 | Valid bytes of the payload word |
| trunc_err | output | 1 | Packet ended early by the marker |

## Verification
The hardest case to reach is a `width_sel` change that lands while a command word is only partly gathered. The same case arises when the change lands mid-packet and the sender keeps using the old lane count. The bench changes the setting between beat cycles of a command word and between payload words. It then sends the following packet at the new count, so a lane count taken too early or too late produces scrambled words. Early end markers are placed on command, address and payload words. A marker is also driven on a beat cycle that does not complete a word, so an unsampled marker that wrongly takes effect shows up as a false truncation.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 4;
    localparam int LEN_LSB   = WORD_W - LEN_W;
    localparam int HASA_BIT  = LEN_LSB - 1;
    localparam int PAD_W     = 2;
    localparam int PAD_LSB   = HASA_BIT - PAD_W;
    localparam int ADDR_HI_W = 8;
    localparam int KEEP_W    = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_ADDR = 2'd1,
        ST_PAY  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/lane_gather.sv
module lane_gather
    import pkt_rx_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int GW     = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_valid,
    input  logic [LANE_W-1:0] lane_even,
    input  logic [LANE_W-1:0] lane_odd,
    input  logic [$clog2($clog2(LANE_W)+1)-1:0] width_sel,
    input  logic              eop_in,
    input  logic              at_boundary,
    output logic              word_done,
    output logic [GW-1:0]     word_data,
    output logic              word_eop
);
    localparam int MAX_SEL = $clog2(LANE_W);
    localparam int SEL_W   = $clog2(MAX_SEL + 1);
    localparam int HALF    = GW / 2;
    localparam int CNT_W   = $clog2(HALF);

    typedef struct packed {
        logic [GW-1:0]    acc;
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] wsel;
    } gat_s;

    gat_s g_d, g_q;
    logic [SEL_W-1:0] sel_eff;
    logic [GW-1:0]    lmask, chunk, placed;
    logic             last_chunk;

    always_comb begin
        if (at_boundary && g_q.cnt == '0)
            sel_eff = (width_sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : width_sel;
        else
            sel_eff = g_q.wsel;
        lmask  = ~({GW{1'b1}} << (1 << sel_eff));
        chunk  = (GW'(lane_even) & lmask)
               | ((GW'(lane_odd) & lmask) << (1 << sel_eff));
        placed = chunk << (32'(g_q.cnt) << (32'(sel_eff) + 1));
        last_chunk = (g_q.cnt == CNT_W'((HALF >> sel_eff) - 1));

        g_d       = g_q;
        word_done = 1'b0;
        word_data = g_q.acc | placed;
        word_eop  = eop_in;
        if (beat_valid) begin
            g_d.wsel = sel_eff;
            if (last_chunk) begin
                word_done = 1'b1;
                g_d.acc   = '0;
                g_d.cnt   = '0;
            end else begin
                g_d.acc = g_q.acc | placed;
                g_d.cnt = g_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q.acc  <= '0;
            g_q.cnt  <= '0;
            g_q.wsel <= SEL_W'(MAX_SEL);
        end else begin
            g_q <= g_d;
        end
    end
endmodule

// File: rtl/pkt_sequencer.sv
module pkt_sequencer
    import pkt_rx_pkg::*;
#(
    parameter int SW = WORD_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    word_done,
    input  logic [SW-1:0]           word_data,
    input  logic                    word_eop,
    output logic                    at_boundary,
    output logic                    cmd_valid,
    output logic [SW-1:0]           cmd_word,
    output logic                    addr_valid,
    output logic [ADDR_HI_W+SW-1:0] addr,
    output logic                    pay_valid,
    output logic [SW-1:0]           pay_data,
    output logic                    pay_last,
    output logic [KEEP_W-1:0]       pay_keep,
    output logic                    trunc_err
);
    typedef struct packed {
        seq_st_e                 st;
        logic [LEN_W-1:0]        remain;
        logic [PAD_W-1:0]        pad;
        logic [ADDR_HI_W-1:0]    hi;
        logic                    cmd_v;
        logic [SW-1:0]           cmd;
        logic                    addr_v;
        logic [ADDR_HI_W+SW-1:0] addr;
        logic                    pay_v;
        logic [SW-1:0]           pay;
        logic                    last;
        logic [KEEP_W-1:0]       keep;
        logic                    err;
    } seq_s;

    seq_s s_d, s_q;
    logic [LEN_W-1:0] w_len;
    logic             w_has;

    always_comb begin
        w_len = word_data[LEN_LSB +: LEN_W];
        w_has = word_data[HASA_BIT];

        s_d        = s_q;
        s_d.cmd_v  = 1'b0;
        s_d.addr_v = 1'b0;
        s_d.pay_v  = 1'b0;
        s_d.last   = 1'b0;
        s_d.err    = 1'b0;
        if (word_done) begin
            unique case (s_q.st)
                ST_CMD: begin
                    s_d.cmd_v  = 1'b1;
                    s_d.cmd    = word_data;
                    s_d.remain = w_len;
                    s_d.pad    = word_data[PAD_LSB +: PAD_W];
                    s_d.hi     = word_data[ADDR_HI_W-1:0];
                    if (word_eop) begin
                        s_d.err = w_has || (w_len != '0);
                        s_d.st  = ST_CMD;
                    end else if (w_has) begin
                        s_d.st = ST_ADDR;
                    end else if (w_len != '0) begin
                        s_d.st = ST_PAY;
                    end else begin
                        s_d.st = ST_CMD;
                    end
                end
                ST_ADDR: begin
                    s_d.addr_v = 1'b1;
                    s_d.addr   = {s_q.hi, word_data};
                    if (word_eop) begin
                        s_d.err = (s_q.remain != '0);
                        s_d.st  = ST_CMD;
                    end else begin
                        s_d.st = (s_q.remain != '0) ? ST_PAY : ST_CMD;
                    end
                end
                default: begin
                    s_d.pay_v  = 1'b1;
                    s_d.pay    = word_data;
                    s_d.last   = (s_q.remain == LEN_W'(1)) || word_eop;
                    s_d.keep   = (s_q.remain == LEN_W'(1)) ? ({KEEP_W{1'b1}} >> s_q.pad)
                                                           : {KEEP_W{1'b1}};
                    s_d.err    = word_eop && (s_q.remain != LEN_W'(1));
                    s_d.remain = s_q.remain - LEN_W'(1);
                    s_d.st     = s_d.last ? ST_CMD : ST_PAY;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign at_boundary = (s_q.st == ST_CMD);
    assign cmd_valid   = s_q.cmd_v;
    assign cmd_word    = s_q.cmd;
    assign addr_valid  = s_q.addr_v;
    assign addr        = s_q.addr;
    assign pay_valid   = s_q.pay_v;
    assign pay_data    = s_q.pay;
    assign pay_last    = s_q.last;
    assign pay_keep    = s_q.keep;
    assign trunc_err   = s_q.err;
endmodule

// File: rtl/pkt_link_rx.sv
module pkt_link_rx
    import pkt_rx_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int RW     = WORD_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          beat_valid,
    input  logic [LANE_W-1:0]             lane_even,
    input  logic [LANE_W-1:0]             lane_odd,
    input  logic [$clog2($clog2(LANE_W)+1)-1:0] width_sel,
    input  logic                          eop_in,
    output logic                          cmd_valid,
    output logic [RW-1:0]                 cmd_word,
    output logic [LEN_W-1:0]              cmd_len,
    output logic                          cmd_has_addr,
    output logic                          addr_valid,
    output logic [ADDR_HI_W+RW-1:0]       addr,
    output logic                          pay_valid,
    output logic [RW-1:0]                 pay_data,
    output logic                          pay_last,
    output logic [KEEP_W-1:0]             pay_keep,
    output logic                          trunc_err
);
    logic          at_boundary, word_done, word_eop;
    logic [RW-1:0] word_data;

    lane_gather #(.LANE_W(LANE_W), .GW(RW)) u_gather (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (beat_valid),
        .lane_even  (lane_even),
        .lane_odd   (lane_odd),
        .width_sel  (width_sel),
        .eop_in     (eop_in),
        .at_boundary(at_boundary),
        .word_done  (word_done),
        .word_data  (word_data),
        .word_eop   (word_eop)
    );

    pkt_sequencer #(.SW(RW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .word_done  (word_done),
        .word_data  (word_data),
        .word_eop   (word_eop),
        .at_boundary(at_boundary),
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .addr_valid (addr_valid),
        .addr       (addr),
        .pay_valid  (pay_valid),
        .pay_data   (pay_data),
        .pay_last   (pay_last),
        .pay_keep   (pay_keep),
        .trunc_err  (trunc_err)
    );

    assign cmd_len      = cmd_word[LEN_LSB +: LEN_W];
    assign cmd_has_addr = cmd_word[HASA_BIT];
endmodule

// File: rtl/pkt_link_rx_chk.sv
module pkt_link_rx_chk
    import pkt_rx_pkg::*;
#(
    parameter int CW = WORD_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    beat_valid,
    input logic                    cmd_valid,
    input logic [CW-1:0]           cmd_word,
    input logic                    addr_valid,
    input logic [ADDR_HI_W+CW-1:0] addr,
    input logic                    pay_valid,
    input logic                    pay_last,
    input logic [KEEP_W-1:0]       pay_keep,
    input logic                    trunc_err
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !(cmd_valid || addr_valid || pay_valid || pay_last || trunc_err));

    // R2
    out_needs_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || addr_valid || pay_valid) |-> $past(beat_valid));

    // R3
    one_kind_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid, addr_valid, pay_valid}));

    // R4
    addr_join_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (addr[ADDR_HI_W+CW-1:CW] == cmd_word[ADDR_HI_W-1:0]));

    // R5
    last_is_pay_chk: assert property (@(posedge clk) disable iff (rst)
        pay_last |-> pay_valid);

    // R5
    keep_only_last_chk: assert property (@(posedge clk) disable iff (rst)
        (pay_valid && pay_keep != {KEEP_W{1'b1}}) |-> pay_last);

    // R7
    err_with_word_chk: assert property (@(posedge clk) disable iff (rst)
        trunc_err |-> (cmd_valid || addr_valid || pay_valid));

    // R7
    err_pay_last_chk: assert property (@(posedge clk) disable iff (rst)
        (trunc_err && pay_valid) |-> pay_last);
endmodule

bind pkt_link_rx pkt_link_rx_chk #(.CW(RW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .beat_valid(beat_valid),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .addr_valid(addr_valid),
    .addr      (addr),
    .pay_valid (pay_valid),
    .pay_last  (pay_last),
    .pay_keep  (pay_keep),
    .trunc_err (trunc_err)
);

// File: tb/sim_pkt_link_rx.sv
module sim_pkt_link_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        beat_valid = 1'b0;
    logic [15:0] lane_even = '0;
    logic [15:0] lane_odd = '0;
    logic [2:0]  width_sel = 3'd4;
    logic        eop_in = 1'b0;
    logic        cmd_valid, cmd_has_addr, addr_valid, pay_valid, pay_last, trunc_err;
    logic [31:0] cmd_word, pay_data;
    logic [3:0]  cmd_len, pay_keep;
    logic [39:0] addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model state
    int          m_st = 0;
    int          m_rem = 0;
    int          m_pad = 0;
    int          m_nb = 0;
    int          m_sel = 4;
    logic [7:0]  m_hi = '0;
    logic [31:0] m_buf = '0;
    bit          e_cmd_v, e_addr_v, e_pay_v, e_last, e_err;
    logic [31:0] e_cmd, e_pay;
    logic [39:0] e_addr;
    logic [3:0]  e_keep;

    always #4 clk = ~clk;

    pkt_link_rx u0 (
        .clk(clk), .rst(rst), .beat_valid(beat_valid), .lane_even(lane_even),
        .lane_odd(lane_odd), .width_sel(width_sel), .eop_in(eop_in),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_len(cmd_len),
        .cmd_has_addr(cmd_has_addr), .addr_valid(addr_valid), .addr(addr),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_last(pay_last),
        .pay_keep(pay_keep), .trunc_err(trunc_err)
    );

    task automatic check(input string req, input bit ok, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s) %s", req, tag, what);
        end
    endtask

    task automatic model_word(input logic [31:0] w, input bit eop);
        if (m_st == 0) begin
            e_cmd_v = 1; e_cmd = w;
            m_rem = int'(w[31:28]); m_pad = int'(w[26:25]); m_hi = w[7:0];
            if (eop) begin
                e_err = w[27] || (m_rem != 0); m_st = 0;
            end else m_st = w[27] ? 1 : ((m_rem != 0) ? 2 : 0);
        end else if (m_st == 1) begin
            e_addr_v = 1; e_addr = {m_hi, w};
            if (eop) begin
                e_err = (m_rem != 0); m_st = 0;
            end else m_st = (m_rem != 0) ? 2 : 0;
        end else begin
            e_pay_v = 1; e_pay = w;
            e_last = (m_rem == 1) || eop;
            e_keep = (m_rem == 1) ? (4'hF >> m_pad) : 4'hF;
            e_err  = eop && (m_rem != 1);
            m_rem--;
            m_st = e_last ? 0 : 2;
        end
    endtask

    task automatic model_step(input bit v, input logic [15:0] ev, input logic [15:0] od, input bit eop);
        int ln;
        e_cmd_v = 0; e_addr_v = 0; e_pay_v = 0; e_last = 0; e_err = 0;
        if (rst) begin
            m_st = 0; m_nb = 0; m_buf = '0; m_sel = 4;
            return;
        end
        if (!v) return;
        if (m_st == 0 && m_nb == 0) m_sel = (width_sel > 3'd4) ? 4 : int'(width_sel);
        ln = 1 << m_sel;
        for (int i = 0; i < ln; i++) begin m_buf[m_nb] = ev[i]; m_nb++; end
        for (int i = 0; i < ln; i++) begin m_buf[m_nb] = od[i]; m_nb++; end
        if (m_nb == 32) begin
            model_word(m_buf, eop);
            m_nb = 0; m_buf = '0;
        end
    endtask

    task automatic compare();
        check("R3", cmd_valid == e_cmd_v &&
              (!e_cmd_v || (cmd_word == e_cmd && cmd_len == e_cmd[31:28] && cmd_has_addr == e_cmd[27])),
              $sformatf("cmd act v=%0b w=%h exp v=%0b w=%h", cmd_valid, cmd_word, e_cmd_v, e_cmd));
        check("R4", addr_valid == e_addr_v && (!e_addr_v || addr == e_addr),
              $sformatf("addr act v=%0b a=%h exp v=%0b a=%h", addr_valid, addr, e_addr_v, e_addr));
        check("R5", pay_valid == e_pay_v && pay_last == e_last &&
              (!e_pay_v || (pay_data == e_pay && pay_keep == e_keep)),
              $sformatf("pay act v=%0b d=%h l=%0b k=%h exp v=%0b d=%h l=%0b k=%h",
                        pay_valid, pay_data, pay_last, pay_keep, e_pay_v, e_pay, e_last, e_keep));
        check("R7", trunc_err == e_err,
              $sformatf("err act %0b exp %0b", trunc_err, e_err));
    endtask

    task automatic tick(input bit v, input logic [15:0] ev, input logic [15:0] od, input bit eop);
        beat_valid = v; lane_even = ev; lane_odd = od; eop_in = eop;
        @(posedge clk);
        model_step(v, ev, od, eop);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        for (int i = 0; i < n; i++) tick(1'b0, 16'h0, 16'h0, 1'b0);
        rst = 1'b0;
    endtask

    // Send one word at 2**lsel lanes; unused lanes carry ones (R2).
    task automatic send_word(input logic [31:0] w, input int lsel, input bit eop,
                             input int gap, input bit early_eop, input int chg_sel);
        int ln, cyc;
        logic [15:0] ev, od;
        ln  = 1 << lsel;
        cyc = 16 >> lsel;
        for (int c = 0; c < cyc; c++) begin
            ev = 16'hFFFF; od = 16'hFFFF;
            for (int i = 0; i < ln; i++) begin
                ev[i] = w[c*2*ln + i];
                od[i] = w[c*2*ln + ln + i];
            end
            tick(1'b1, ev, od, (c == cyc-1) ? eop : (early_eop && c == 0));
            if (c == 0 && chg_sel >= 0) width_sel = 3'(chg_sel);
            // R10: idle cycles with junk data and marker
            for (int g = 0; g < gap; g++) tick(1'b0, 16'hA5C3, 16'h3C5A, 1'b1);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input int len, input bit has, input int pad,
                                           input logic [7:0] hi, input logic [16:0] mid);
        return {4'(len), has, 2'(pad), mid, hi};
    endfunction

    initial begin
        #(8*150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        do_reset(3);
        check("R1", !cmd_valid && !addr_valid && !pay_valid && !pay_last && !trunc_err,
              $sformatf("reset outputs act %0b%0b%0b%0b%0b exp 00000",
                        cmd_valid, addr_valid, pay_valid, pay_last, trunc_err));

        // R2 R3 R5: 16 lanes, two payload words
        tag = "R2"; width_sel = 3'd4;
        send_word(mk_cmd(2, 0, 0, 8'h11, 17'h1_2345), 4, 0, 0, 0, -1);
        send_word(32'hDEAD_BEEF, 4, 0, 0, 0, -1);
        send_word(32'h0BAD_F00D, 4, 1, 0, 0, -1);

        // R4: 8 lanes, address and padded last word
        tag = "R4"; width_sel = 3'd3;
        send_word(mk_cmd(1, 1, 2, 8'hA5, 17'h0_0F0F), 3, 0, 0, 0, -1);
        send_word(32'h1234_5678, 3, 0, 0, 0, -1);
        send_word(32'hCAFE_1234, 3, 1, 0, 0, -1);

        // R2: 1 lane, command only
        tag = "R2"; width_sel = 3'd0;
        send_word(mk_cmd(0, 0, 0, 8'h3C, 17'h1_FFFF), 0, 1, 0, 0, -1);

        // R10: 2 and 4 lanes with idle gaps
        tag = "R10"; width_sel = 3'd1;
        send_word(mk_cmd(1, 0, 3, 8'h00, 17'h0_AAAA), 1, 0, 1, 0, -1);
        send_word(32'h8765_4321, 1, 1, 1, 0, -1);
        width_sel = 3'd2;
        send_word(mk_cmd(1, 1, 1, 8'hF0, 17'h1_5555), 2, 0, 2, 0, -1);
        send_word(32'h0000_FFFF, 2, 0, 2, 0, -1);
        send_word(32'h5A5A_A5A5, 2, 1, 2, 0, -1);

        // R6: packet ends by count without a marker
        tag = "R6"; width_sel = 3'd4;
        send_word(mk_cmd(1, 0, 0, 8'h77, 17'h0_1111), 4, 0, 0, 0, -1);
        send_word(32'h1357_9BDF, 4, 0, 0, 0, -1);
        send_word(mk_cmd(0, 1, 0, 8'h88, 17'h0_2222), 4, 0, 0, 0, -1);
        send_word(32'hFEDC_BA98, 4, 0, 0, 0, -1);

        // R7: truncated payload, address and command words
        tag = "R7";
        send_word(mk_cmd(3, 0, 1, 8'h01, 17'h0_3333), 4, 0, 0, 0, -1);
        send_word(32'h0000_0001, 4, 0, 0, 0, -1);
        send_word(32'h0000_0002, 4, 1, 0, 0, -1);
        send_word(mk_cmd(2, 1, 0, 8'h02, 17'h0_4444), 4, 0, 0, 0, -1);
        send_word(32'h0000_0003, 4, 1, 0, 0, -1);
        send_word(mk_cmd(0, 1, 0, 8'h03, 17'h0_5555), 4, 1, 0, 0, -1);
        send_word(mk_cmd(1, 0, 0, 8'h04, 17'h0_6666), 4, 0, 0, 0, -1);
        send_word(32'h0000_0004, 4, 1, 0, 0, -1);

        // R8: marker on a non-completing beat is ignored
        tag = "R8"; width_sel = 3'd2;
        send_word(mk_cmd(2, 0, 0, 8'h05, 17'h0_7777), 2, 0, 0, 1, -1);
        send_word(32'h2468_ACE0, 2, 0, 0, 1, -1);
        send_word(32'h1111_2222, 2, 1, 0, 1, -1);

        // R9: width change mid-packet and mid-command word
        tag = "R9"; width_sel = 3'd3;
        send_word(mk_cmd(2, 0, 0, 8'h06, 17'h0_8888), 3, 0, 0, 0, 4);
        send_word(32'h3333_4444, 3, 0, 0, 0, -1);
        send_word(32'h5555_6666, 3, 1, 0, 0, -1);
        send_word(mk_cmd(1, 0, 0, 8'h07, 17'h0_9999), 4, 0, 0, 0, 1);
        width_sel = 3'd2;
        send_word(32'h7777_8888, 4, 1, 0, 0, -1);
        send_word(mk_cmd(1, 0, 2, 8'h08, 17'h0_ABCD), 2, 0, 0, 0, 0);
        send_word(32'h9999_AAAA, 2, 1, 0, 0, -1);

        // R2: codes above 4 act as 16 lanes
        tag = "R2"; width_sel = 3'd6;
        send_word(mk_cmd(1, 1, 0, 8'h09, 17'h1_0001), 4, 0, 0, 0, -1);
        send_word(32'hBBBB_CCCC, 4, 0, 0, 0, -1);
        send_word(32'hDDDD_EEEE, 4, 1, 0, 0, -1);

        // R1: reset discards a partial word
        tag = "R1"; width_sel = 3'd0;
        for (int c = 0; c < 5; c++) tick(1'b1, 16'hFFFF, 16'hFFFE, 1'b0);
        do_reset(2);
        width_sel = 3'd4;
        send_word(mk_cmd(1, 0, 0, 8'h0A, 17'h0_0002), 4, 0, 0, 0, -1);
        send_word(32'hFACE_0FF0, 4, 1, 0, 0, -1);
        for (int i = 0; i < 3; i++) tick(1'b0, 16'h0, 16'h0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule